// File: doc/BRIEF.md
# Latched Serial-to-Parallel Column Driver

This block turns a slow serial bit stream into a wide set of per-channel on/off enables. It is meant for column drive in display panels and print heads. A host toggles a serial clock and a serial data line. Each falling edge of the serial clock pushes one bit into a chain of stages. A cascade output copies the far end of the chain, so several blocks can be daisy-chained on one data line. A bank of holding registers sits between the chain and the channel outputs. While the load control is high the bank is transparent; while it is low the bank holds its value. Two global controls then shape the final enables. One inverts the data. The other blanks every channel, forcing all channels on or all off.

Everything runs on one fast system clock. The serial clock, serial data, load, blanking and polarity inputs arrive without any timing relation to that clock. They pass through a multi-stage synchronizer, and the serial clock's falling edge is found by comparing successive synchronized samples. Stage count, channel count and synchronizer depth are parameters.

Top module: `col_driver`

## Requirements
- R1: A falling edge on `ser_clk_i` moves every stage k to stage k+1 and loads the synchronized `ser_dat_i` into stage 1. Stage k drives bit k-1 of the internal chain. A rising edge, or no edge, leaves the chain unchanged.
- R2: `cascade_o` always equals the last stage (stage CHANNELS), so it repeats the bit that entered CHANNELS falling edges earlier.
- R3: The chain contents depend only on the serial clock and data. Load, blanking and polarity never stall or change the shifting.
- R4: While synchronized `load_i` is high, the holding bank follows the chain, taking the post-shift value in a cycle that also shifts. While it is low, the bank keeps its value.
- R5: While `blank_n_i` is low, every bit of `chan_on_o` is 1 if `pol_i` is low, and every bit is 0 if `pol_i` is high, whatever the bank holds.
- R6: While `blank_n_i` is high, `chan_on_o[c]` equals held bit c when `pol_i` is high and its inverse when `pol_i` is low.
- R7: A synchronous `rst` clears the chain and the bank to zero. The synchronizers reset to serial clock low, load low, blanking inactive and polarity high, so all channels read 0 during and just after reset.
- R8: A change on `pol_i` or `blank_n_i` reaches `chan_on_o` after exactly SYNC_STAGES rising edges of `clk`. A falling edge on `ser_clk_i` changes `cascade_o` after exactly SYNC_STAGES+1 rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk_i | input | 1 | Serial shift clock, shifts on its falling edge |
| ser_dat_i | input | 1 | Serial data entering stage 1 |
| load_i | input | 1 | Holding bank transparent when high, holds when low |
| blank_n_i | input | 1 | Blanking, active low |
| pol_i | input | 1 | Polarity: high passes data, low inverts |
| cascade_o | output | 1 | Last stage, for chaining a downstream block |
| chan_on_o | output | CHANNELS | Per-channel on enables |

## Verification
The bench builds the block with its default values: 32 channels and a two-flop synchronizer. At that size a full frame of 32 bits fills the chain, so the cascade output shows data from the very first bit pushed. Those values also make the latency edges land on fixed cycles, which lets the bench probe one cycle before and one cycle at each expected change. Directed scenarios cover each blanking and polarity combination. They shift with the bank both transparent and holding, and shift while blanking is active. A reset is applied in mid-stream. A randomized run then mixes bit pushes with toggling of load, blanking and polarity, all checked against a bench-side model.

// File: rtl/cdrv_pkg.sv
package cdrv_pkg;

   // Bundle of asynchronous control and data inputs passed through the synchronizer
   typedef struct packed {
      logic sclk;
      logic sdat;
      logic load;
      logic blank_n;
      logic pol;
   } cdrv_in_t;

   localparam int CDRV_IN_W = $bits(cdrv_in_t);

   // Idle state: no shift, bank holding, not blanked, non-inverting
   localparam cdrv_in_t CDRV_IN_IDLE = '{sclk: 1'b0, sdat: 1'b0, load: 1'b0,
                                        blank_n: 1'b1, pol: 1'b1};

endpackage

// File: rtl/cdrv_sync.sv
module cdrv_sync #(
   parameter int                WIDTH   = 1,
   parameter int                STAGES  = 2,
   parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("cdrv_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         stg_q <= {STAGES{RST_VAL}};
      end else begin
         stg_q <= {stg_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = stg_q[LAST];

endmodule

// File: rtl/cdrv_shift.sv
module cdrv_shift #(
   parameter int CHANNELS = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                sclk_s,
   input  logic                sdat_s,
   output logic                fall_o,
   output logic [CHANNELS-1:0] stage_q,
   output logic [CHANNELS-1:0] stage_nxt
);

   logic sclk_prev_q;

   // Falling edge: previous synchronized sample high, current low
   assign fall_o    = sclk_prev_q & ~sclk_s;
   assign stage_nxt = fall_o ? {stage_q[CHANNELS-2:0], sdat_s} : stage_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         stage_q     <= '0;
         sclk_prev_q <= 1'b0;
      end else begin
         stage_q     <= stage_nxt;
         sclk_prev_q <= sclk_s;
      end
   end

   p_shift_r1: assert property (@(posedge clk) disable iff (rst)
      fall_o |=> (stage_q[CHANNELS-1:1] == $past(stage_q[CHANNELS-2:0]))
                 && (stage_q[0] == $past(sdat_s)));

   p_no_edge_r1: assert property (@(posedge clk) disable iff (rst)
      !fall_o |=> $stable(stage_q));

   p_edge_needs_high_r1: assert property (@(posedge clk) disable iff (rst)
      fall_o |-> $fell(sclk_s));

endmodule

// File: rtl/cdrv_latch.sv
module cdrv_latch #(
   parameter int CHANNELS = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                load_s,
   input  logic [CHANNELS-1:0] stage_nxt,
   input  logic [CHANNELS-1:0] stage_q,
   output logic [CHANNELS-1:0] lat_q
);

   // Level-sensitive bank modelled as a register reloaded every cycle load is high
   always_ff @(posedge clk) begin
      if (rst) begin
         lat_q <= '0;
      end else if (load_s) begin
         lat_q <= stage_nxt;
      end
   end

   p_follow_r4: assert property (@(posedge clk) disable iff (rst)
      load_s |=> (lat_q == stage_q));

   p_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !load_s |=> $stable(lat_q));

endmodule

// File: rtl/cdrv_outmux.sv
module cdrv_outmux #(
   parameter int CHANNELS = 32
) (
   input  logic [CHANNELS-1:0] lat_q,
   input  logic                blank_n_s,
   input  logic                pol_s,
   output logic [CHANNELS-1:0] on_o
);

   for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
      // Not blanked: pass or invert. Blanked: level set by polarity alone.
      assign on_o[c] = blank_n_s ? (lat_q[c] ~^ pol_s) : ~pol_s;
   end

endmodule

// File: rtl/col_driver.sv
module col_driver
   import cdrv_pkg::*;
#(
   parameter int CHANNELS    = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                ser_clk_i,
   input  logic                ser_dat_i,
   input  logic                load_i,
   input  logic                blank_n_i,
   input  logic                pol_i,
   output logic                cascade_o,
   output logic [CHANNELS-1:0] chan_on_o
);

   localparam int LAST = CHANNELS - 1;

   if (CHANNELS < 2) begin : g_bad_channels
      $error("col_driver: CHANNELS must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("col_driver: SYNC_STAGES must be at least 2");
   end

   cdrv_in_t            raw_in;
   cdrv_in_t            sy;
   logic                fall;
   logic [CHANNELS-1:0] stage_q;
   logic [CHANNELS-1:0] stage_nxt;
   logic [CHANNELS-1:0] lat_q;

   assign raw_in = '{sclk: ser_clk_i, sdat: ser_dat_i, load: load_i,
                     blank_n: blank_n_i, pol: pol_i};

   cdrv_sync #(
      .WIDTH   (CDRV_IN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (CDRV_IN_IDLE)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d_i (raw_in),
      .q_o (sy)
   );

   cdrv_shift #(.CHANNELS(CHANNELS)) u_shift (
      .clk       (clk),
      .rst       (rst),
      .sclk_s    (sy.sclk),
      .sdat_s    (sy.sdat),
      .fall_o    (fall),
      .stage_q   (stage_q),
      .stage_nxt (stage_nxt)
   );

   cdrv_latch #(.CHANNELS(CHANNELS)) u_latch (
      .clk       (clk),
      .rst       (rst),
      .load_s    (sy.load),
      .stage_nxt (stage_nxt),
      .stage_q   (stage_q),
      .lat_q     (lat_q)
   );

   cdrv_outmux #(.CHANNELS(CHANNELS)) u_outmux (
      .lat_q     (lat_q),
      .blank_n_s (sy.blank_n),
      .pol_s     (sy.pol),
      .on_o      (chan_on_o)
   );

   assign cascade_o = stage_q[LAST];

   p_cascade_r2: assert property (@(posedge clk) disable iff (rst)
      fall |=> (cascade_o == $past(stage_q[LAST-1])));

   p_blank_off_r5: assert property (@(posedge clk) disable iff (rst)
      (!sy.blank_n && sy.pol) |-> ($countones(chan_on_o) == 0));

   p_blank_on_r5: assert property (@(posedge clk) disable iff (rst)
      (!sy.blank_n && !sy.pol) |-> ($countones(chan_on_o) == CHANNELS));

   p_pass_r6: assert property (@(posedge clk) disable iff (rst)
      (sy.blank_n && sy.pol) |-> (chan_on_o == lat_q));

   p_invert_r6: assert property (@(posedge clk) disable iff (rst)
      (sy.blank_n && !sy.pol) |-> (chan_on_o == ~lat_q));

   p_clear_r7: assert property (@(posedge clk)
      rst |=> ((stage_q == '0) && (lat_q == '0)));

endmodule

// File: tb/col_driver_tb.sv
`timescale 1ns/1ps
module col_driver_tb;

   localparam int CH   = 32;
   localparam int SYNC = 2;

   logic          clk = 1'b0;
   logic          rst;
   logic          ser_clk, ser_dat, load, blank_n, pol;
   logic          cascade;
   logic [CH-1:0] chan_on;

   int vectors = 0;
   int miscomp = 0;

   logic [CH-1:0] m_sh, m_lat;
   logic          m_le, m_bn, m_pol;

   always #4 clk = ~clk;

   col_driver #(.CHANNELS(CH), .SYNC_STAGES(SYNC)) u_dut (
      .clk       (clk),
      .rst       (rst),
      .ser_clk_i (ser_clk),
      .ser_dat_i (ser_dat),
      .load_i    (load),
      .blank_n_i (blank_n),
      .pol_i     (pol),
      .cascade_o (cascade),
      .chan_on_o (chan_on)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [CH-1:0] exp_on();
      if (!m_bn) return m_pol ? '0 : '1;
      return m_pol ? m_lat : ~m_lat;
   endfunction

   task automatic chk(input string req);
      logic [CH-1:0] e;
      e = exp_on();
      vectors++;
      if (chan_on !== e || cascade !== m_sh[CH-1]) begin
         miscomp++;
         $display("FAIL %s: chan=%h cas=%b expected chan=%h cas=%b",
                  req, chan_on, cascade, e, m_sh[CH-1]);
      end
   endtask

   task automatic chk_vec(input string req, input logic [CH-1:0] act, input logic [CH-1:0] exp);
      vectors++;
      if (act !== exp) begin
         miscomp++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push(input logic b);
      ser_dat = b;
      ser_clk = 1'b1;
      step(4);
      ser_clk = 1'b0;
      step(4);
      m_sh = {m_sh[CH-2:0], b};
      if (m_le) m_lat = m_sh;
   endtask

   task automatic set_le(input logic v);
      load = v; m_le = v;
      if (v) m_lat = m_sh;
      step(4);
   endtask

   task automatic set_bp(input logic bn, input logic p);
      blank_n = bn; pol = p; m_bn = bn; m_pol = p;
      step(4);
   endtask

   // R7: reset state
   task automatic t_reset();
      rst = 1'b1; ser_clk = 0; ser_dat = 0; load = 0; blank_n = 1; pol = 1;
      m_sh = '0; m_lat = '0; m_le = 0; m_bn = 1; m_pol = 1;
      step(4);
      chk("R7 outputs during reset");
      rst = 1'b0;
      step(2);
      chk("R7 outputs after reset");
   endtask

   // R1 R2 R4: fill chain with bank holding, then load it
   task automatic t_fill_hold();
      logic [CH-1:0] pat = 32'hC3A5_9617;
      for (int i = CH - 1; i >= 0; i--) begin
         push(pat[i]);
         chk("R2 cascade during fill, R4 bank holds");
      end
      chk_vec("R1 frame order after fill", chan_on, '0);
      set_le(1'b1);
      chk_vec("R1 frame lands in stage order", chan_on, pat);
      set_le(1'b0);
      push(1'b0);
      chk("R4 hold after load dropped");
   endtask

   // R5 R6: polarity and blanking combinations
   task automatic t_polarity();
      set_bp(1'b1, 1'b0); chk("R6 invert");
      set_bp(1'b0, 1'b0); chk("R5 blank all on");
      set_bp(1'b0, 1'b1); chk("R5 blank all off");
      set_bp(1'b1, 1'b1); chk("R6 pass through");
   endtask

   // R3: shifting while blanked and inverted, then reveal
   task automatic t_independent();
      set_bp(1'b0, 1'b0);
      for (int i = 0; i < CH; i++) begin
         push(i[0] ^ i[2]);
         chk("R3 shift while blanked");
      end
      set_bp(1'b1, 1'b1);
      set_le(1'b1);
      chk_vec("R3 chain unaffected by blank/pol", chan_on, m_sh);
      set_le(1'b0);
   endtask

   // R4: transparent bank follows each shift
   task automatic t_transparent();
      set_le(1'b1);
      for (int i = 0; i < 12; i++) begin
         push(i[0]);
         chk("R4 transparent follows shift");
      end
      set_le(1'b0);
   endtask

   // R8: exact latency of control and serial edges
   task automatic t_latency();
      logic [CH-1:0] old_on;
      logic          nxt;
      old_on = chan_on;
      pol = 1'b0;
      step(SYNC - 1);
      chk_vec("R8 pol not yet visible", chan_on, old_on);
      step(1);
      chk_vec("R8 pol visible on time", chan_on, ~m_lat);
      m_pol = 1'b0;
      set_bp(1'b1, 1'b1);
      nxt = m_sh[CH-2];
      ser_dat = ~m_sh[0];
      ser_clk = 1'b1;
      step(4);
      ser_clk = 1'b0;
      step(SYNC);
      chk_vec("R8 cascade not yet shifted", {{(CH-1){1'b0}}, cascade}, {{(CH-1){1'b0}}, m_sh[CH-1]});
      step(1);
      chk_vec("R8 cascade shifted on time", {{(CH-1){1'b0}}, cascade}, {{(CH-1){1'b0}}, nxt});
      step(3);
      m_sh = {m_sh[CH-2:0], ser_dat};
      if (m_le) m_lat = m_sh;
      chk("R8 settled");
   endtask

   // R7: reset in mid-stream
   task automatic t_reset_mid();
      set_le(1'b1);
      push(1'b1);
      set_le(1'b0);
      rst = 1'b1;
      step(2);
      rst = 1'b0;
      m_sh = '0; m_lat = '0;
      step(1);
      chk("R7 mid-stream reset clears");
      set_le(1'b1);
      chk("R7 chain was cleared");
      set_le(1'b0);
   endtask

   // Mixed random traffic against the model
   task automatic t_random();
      for (int i = 0; i < 400; i++) begin
         case ($urandom_range(0, 5))
            0, 1, 2: push(1'($urandom_range(0, 1)));
            3:       set_le(~m_le);
            4:       set_bp(1'($urandom_range(0, 1)), m_pol);
            default: set_bp(m_bn, 1'($urandom_range(0, 1)));
         endcase
         chk("R1 R2 R3 R4 R5 R6 random mix");
      end
   endtask

   initial begin
      t_reset();
      t_fill_hold();
      t_polarity();
      t_independent();
      t_transparent();
      t_latency();
      t_reset_mid();
      t_random();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      miscomp++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
   end

endmodule